// File: doc/BRIEF.md
# Streaming JSON Syntax Checker

This block decides whether a stream of bytes forms one well-formed JSON value. The host presents one byte per cycle with a strobe. A combinational encoder sorts each byte into one of 29 character classes. A bit-parallel nondeterministic automaton then advances a 64-bit state vector in which every grammar position has its own flip-flop. Several bits may be set together, and the next byte decides which of them survive. Object and array nesting is tracked by a small pushdown stack of opener tags.

Two outputs report the verdict. `accept_o` is high whenever the bytes seen so far form a complete value at nesting depth zero. `error_o` is a sticky flag: it rises on the first byte that cannot continue any live interpretation, or on a stack fault, and it stays high until reset. Only reset starts a new document.

Top module: `json_nfa_validator`

## Requirements
- R1: After synchronous active-low reset, `accept_o` and `error_o` are low, the nesting depth is zero and only the value-expected state is active. A lone digit sent next is therefore accepted.
- R2: A nonzero leading digit leaves both the multi-digit-integer position and the complete-value position active. A further digit keeps the value complete. A `.` clears completion until a fraction digit arrives. A comma at depth zero, or a digit after a leading `0`, raises the error flag.
- R3: Inside an array or an object, a comma continues only from the complete-value position and leads to the next element or key. A matching closer returns to the complete-value position one level up.
- R4: The literals `true`, `false` and `null` match lowercase letters only, so `truE` raises the error flag. A number exponent marker is accepted as either `e` (0x65) or `E` (0x45), with an optional sign.
- R5: Inside a string, the escapes `\"`, `\\`, `\/`, `\b`, `\f`, `\n`, `\r` and `\t` are accepted. `\u` is followed by any four bytes, which are not checked for hex digits. Any other byte after a backslash raises the error flag.
- R6: The nesting stack holds 16 openers (parameter `DEPTH`). Sixteen nested `[` followed by sixteen `]` are accepted. A seventeenth opener raises the error flag.
- R7: A closer that does not match the innermost opener, or a closer at depth zero, raises the error flag.
- R8: Whitespace bytes (0x20, 0x09, 0x0A, 0x0D) outside strings leave structural positions unchanged. Inside a number or a literal they end that token, so `1 2` raises the error flag.
- R9: Once `error_o` is high it stays high, `accept_o` stays low, and further bytes have no effect until reset.
- R10: `accept_o` is high only when the complete-value position is active, the depth is zero and no error has occurred. An unclosed `[1` or a partial `nul` gives neither accept nor error.
- R11: A cycle with `in_valid` low changes neither the automaton state nor the stack, whatever `in_byte` holds.
- R12: A control byte below 0x20 other than the whitespace bytes, when received inside a string, raises the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_byte` is consumed this cycle |
| in_byte | input | 8 | Input byte |
| accept_o | output | 1 | Bytes so far form one complete value |
| error_o | output | 1 | Sticky syntax or nesting fault |

## Verification
The hardest situation to reach is the boundary of the nesting stack. Accepting sixteen levels and faulting only on the seventeenth both need long, exactly counted opener runs with no other error on the way. The stimulus drives these runs as directed loops that check the flags after the sixteenth and the seventeenth opener. The multi-hot states are reached by table vectors that end in the middle of a number or literal, where one state bit must die and another survive on the next byte.

// File: rtl/json_nfa_pkg.sv
// Shared definitions for the JSON automaton: character classes, state
// bit positions, masks and stack tag codes. Assumes a 64-bit state vector.
package json_nfa_pkg;

    localparam int NFA_W = 64;
    localparam int TAG_W = 4;

    typedef enum logic [4:0] {
        C_WS, C_LBRACE, C_RBRACE, C_LBRACK, C_RBRACK, C_COLON, C_COMMA,
        C_QUOTE, C_BSLASH, C_SLASH, C_MINUS, C_PLUS, C_DOT, C_ZERO, C_DIGIT,
        C_E_LO, C_E_UP, C_LT_T, C_LT_R, C_LT_U, C_LT_F, C_LT_A, C_LT_L,
        C_LT_S, C_LT_N, C_LT_B, C_CTRL, C_HIGH, C_OTHER
    } char_cls_e;

    // Structural positions
    localparam int S_VAL       = 0;
    localparam int S_OBJ_FIRST = 1;
    localparam int S_OBJ_KEY   = 2;
    localparam int S_COLON     = 3;
    localparam int S_ARR_FIRST = 4;
    // String sub-machines: base, escape, four raw bytes after \u
    localparam int S_STR       = 5;
    localparam int S_KEY       = 11;
    // Numbers
    localparam int S_NEG       = 17;
    localparam int S_ZERO      = 18;
    localparam int S_INTNZ     = 19;
    localparam int S_FRAC0     = 20;
    localparam int S_FRAC      = 21;
    localparam int S_EXP0      = 22;
    localparam int S_EXPS      = 23;
    localparam int S_EXPD      = 24;
    // Literal prefixes
    localparam int S_T1 = 25, S_T2 = 26, S_T3 = 27;
    localparam int S_F1 = 28, S_F2 = 29, S_F3 = 30, S_F4 = 31;
    localparam int S_N1 = 32, S_N2 = 33, S_N3 = 34;
    // Complete value
    localparam int S_ACC       = 63;

    localparam logic [NFA_W-1:0] LIVE_MASK = {1'b1, 28'b0, 35'h7FFFFFFFF};
    localparam logic [NFA_W-1:0] KEEP_WS   = {1'b1, 58'b0, 5'b11111};

    localparam logic [TAG_W-1:0] TAG_OBJ = 4'd1;
    localparam logic [TAG_W-1:0] TAG_ARR = 4'd2;

endpackage

// File: rtl/json_char_class.sv
// Byte-to-class encoder. Purely combinational; assumes ASCII input.
// Letters used by literals get lowercase-only classes; e and E differ.
module json_char_class
    import json_nfa_pkg::*;
(
    input  logic [7:0] byte_i,
    output char_cls_e  cls_o
);

    // Map the byte to its class
    always_comb begin
        case (byte_i) inside
            8'h20, 8'h09, 8'h0A, 8'h0D: cls_o = C_WS;
            8'h7B: cls_o = C_LBRACE;
            8'h7D: cls_o = C_RBRACE;
            8'h5B: cls_o = C_LBRACK;
            8'h5D: cls_o = C_RBRACK;
            8'h3A: cls_o = C_COLON;
            8'h2C: cls_o = C_COMMA;
            8'h22: cls_o = C_QUOTE;
            8'h5C: cls_o = C_BSLASH;
            8'h2F: cls_o = C_SLASH;
            8'h2D: cls_o = C_MINUS;
            8'h2B: cls_o = C_PLUS;
            8'h2E: cls_o = C_DOT;
            8'h30: cls_o = C_ZERO;
            [8'h31:8'h39]: cls_o = C_DIGIT;
            8'h65: cls_o = C_E_LO;
            8'h45: cls_o = C_E_UP;
            8'h74: cls_o = C_LT_T;
            8'h72: cls_o = C_LT_R;
            8'h75: cls_o = C_LT_U;
            8'h66: cls_o = C_LT_F;
            8'h61: cls_o = C_LT_A;
            8'h6C: cls_o = C_LT_L;
            8'h73: cls_o = C_LT_S;
            8'h6E: cls_o = C_LT_N;
            8'h62: cls_o = C_LT_B;
            [8'h00:8'h1F]: cls_o = C_CTRL;
            [8'h80:8'hFF]: cls_o = C_HIGH;
            default: cls_o = C_OTHER;
        endcase
    end

endmodule

// File: rtl/json_nest_stack.sv
// Pushdown stack of opener tags. Push when full and pop when empty are
// ignored; the caller detects and reports those faults.
module json_nest_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  top,
    output logic [PW-1:0] depth,
    output logic          full,
    output logic          empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_m1;

    assign ptr_m1 = ptr - 1'b1;
    assign full   = (ptr == PW'(DEPTH));
    assign empty  = (ptr == '0);
    assign top    = mem[ptr_m1[AW-1:0]];
    assign depth  = ptr;

    // Track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (push && !full)
            ptr <= ptr + 1'b1;
        else if (pop && !empty)
            ptr <= ptr_m1;
    end

    // Store pushed tags
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[ptr[AW-1:0]] <= din;
    end

endmodule

// File: rtl/json_nfa_next.sv
// Next-state function of the bit-parallel automaton. Every active bit adds
// its destinations for the current class; the result is their OR. Also
// requests stack pushes and pops and flags bits outside the grammar.
module json_nfa_next
    import json_nfa_pkg::*;
(
    input  logic [NFA_W-1:0] cur_i,
    input  char_cls_e        cls_i,
    input  logic [TAG_W-1:0] top_tag_i,
    input  logic             stk_empty_i,
    output logic [NFA_W-1:0] nxt_o,
    output logic             push_o,
    output logic [TAG_W-1:0] push_tag_o,
    output logic             pop_o,
    output logic [TAG_W-1:0] pop_tag_o,
    output logic             stray_o
);

    logic [NFA_W-1:0] base_nxt;
    logic             is_dig;
    logic             is_exp;

    assign is_dig  = (cls_i == C_ZERO) || (cls_i == C_DIGIT);
    assign is_exp  = (cls_i == C_E_LO) || (cls_i == C_E_UP);
    assign stray_o = |(cur_i & ~LIVE_MASK);

    // Structure, numbers and literals
    always_comb begin
        base_nxt   = '0;
        push_o     = 1'b0;
        push_tag_o = TAG_ARR;
        pop_o      = 1'b0;
        pop_tag_o  = TAG_ARR;
        if (cls_i == C_WS)
            base_nxt = cur_i & KEEP_WS;
        if (cur_i[S_VAL] || cur_i[S_ARR_FIRST]) begin
            case (cls_i)
                C_LBRACE: begin base_nxt[S_OBJ_FIRST] = 1'b1; push_o = 1'b1; push_tag_o = TAG_OBJ; end
                C_LBRACK: begin base_nxt[S_ARR_FIRST] = 1'b1; push_o = 1'b1; push_tag_o = TAG_ARR; end
                C_QUOTE:  base_nxt[S_STR] = 1'b1;
                C_MINUS:  base_nxt[S_NEG] = 1'b1;
                C_ZERO:   begin base_nxt[S_ZERO] = 1'b1; base_nxt[S_ACC] = 1'b1; end
                C_DIGIT:  begin base_nxt[S_INTNZ] = 1'b1; base_nxt[S_ACC] = 1'b1; end
                C_LT_T:   base_nxt[S_T1] = 1'b1;
                C_LT_F:   base_nxt[S_F1] = 1'b1;
                C_LT_N:   base_nxt[S_N1] = 1'b1;
                default:  ;
            endcase
        end
        if (cur_i[S_ARR_FIRST] && cls_i == C_RBRACK) begin
            base_nxt[S_ACC] = 1'b1; pop_o = 1'b1; pop_tag_o = TAG_ARR;
        end
        if (cur_i[S_OBJ_FIRST] && cls_i == C_QUOTE) base_nxt[S_KEY] = 1'b1;
        if (cur_i[S_OBJ_FIRST] && cls_i == C_RBRACE) begin
            base_nxt[S_ACC] = 1'b1; pop_o = 1'b1; pop_tag_o = TAG_OBJ;
        end
        if (cur_i[S_OBJ_KEY] && cls_i == C_QUOTE) base_nxt[S_KEY] = 1'b1;
        if (cur_i[S_COLON] && cls_i == C_COLON) base_nxt[S_VAL] = 1'b1;
        if (cur_i[S_ACC]) begin
            if (cls_i == C_COMMA && !stk_empty_i) begin
                if (top_tag_i == TAG_OBJ) base_nxt[S_OBJ_KEY] = 1'b1;
                if (top_tag_i == TAG_ARR) base_nxt[S_VAL] = 1'b1;
            end
            if (cls_i == C_RBRACE) begin base_nxt[S_ACC] = 1'b1; pop_o = 1'b1; pop_tag_o = TAG_OBJ; end
            if (cls_i == C_RBRACK) begin base_nxt[S_ACC] = 1'b1; pop_o = 1'b1; pop_tag_o = TAG_ARR; end
        end
        // Numbers
        if (cur_i[S_NEG] && cls_i == C_ZERO)  begin base_nxt[S_ZERO] = 1'b1; base_nxt[S_ACC] = 1'b1; end
        if (cur_i[S_NEG] && cls_i == C_DIGIT) begin base_nxt[S_INTNZ] = 1'b1; base_nxt[S_ACC] = 1'b1; end
        if (cur_i[S_INTNZ] && is_dig) begin base_nxt[S_INTNZ] = 1'b1; base_nxt[S_ACC] = 1'b1; end
        if ((cur_i[S_ZERO] || cur_i[S_INTNZ]) && cls_i == C_DOT) base_nxt[S_FRAC0] = 1'b1;
        if ((cur_i[S_ZERO] || cur_i[S_INTNZ] || cur_i[S_FRAC]) && is_exp) base_nxt[S_EXP0] = 1'b1;
        if ((cur_i[S_FRAC0] || cur_i[S_FRAC]) && is_dig) begin base_nxt[S_FRAC] = 1'b1; base_nxt[S_ACC] = 1'b1; end
        if (cur_i[S_EXP0] && (cls_i == C_PLUS || cls_i == C_MINUS)) base_nxt[S_EXPS] = 1'b1;
        if ((cur_i[S_EXP0] || cur_i[S_EXPS] || cur_i[S_EXPD]) && is_dig) begin
            base_nxt[S_EXPD] = 1'b1; base_nxt[S_ACC] = 1'b1;
        end
        // Literals, lowercase only
        if (cur_i[S_T1] && cls_i == C_LT_R) base_nxt[S_T2] = 1'b1;
        if (cur_i[S_T2] && cls_i == C_LT_U) base_nxt[S_T3] = 1'b1;
        if (cur_i[S_T3] && cls_i == C_E_LO) base_nxt[S_ACC] = 1'b1;
        if (cur_i[S_F1] && cls_i == C_LT_A) base_nxt[S_F2] = 1'b1;
        if (cur_i[S_F2] && cls_i == C_LT_L) base_nxt[S_F3] = 1'b1;
        if (cur_i[S_F3] && cls_i == C_LT_S) base_nxt[S_F4] = 1'b1;
        if (cur_i[S_F4] && cls_i == C_E_LO) base_nxt[S_ACC] = 1'b1;
        if (cur_i[S_N1] && cls_i == C_LT_U) base_nxt[S_N2] = 1'b1;
        if (cur_i[S_N2] && cls_i == C_LT_L) base_nxt[S_N3] = 1'b1;
        if (cur_i[S_N3] && cls_i == C_LT_L) base_nxt[S_ACC] = 1'b1;
    end

    // One string sub-machine per flavour: value strings end in a complete
    // value, key strings end where a colon is expected
    for (genvar g = 0; g < 2; g++) begin : g_str
        localparam int B    = (g == 0) ? S_STR : S_KEY;
        localparam int DONE = (g == 0) ? S_ACC : S_COLON;
        logic [NFA_W-1:0] part;

        // Body, escape and the four raw bytes after \u
        always_comb begin
            part = '0;
            if (cur_i[B]) begin
                case (cls_i)
                    C_QUOTE:  part[DONE]  = 1'b1;
                    C_BSLASH: part[B + 1] = 1'b1;
                    C_CTRL:   ;
                    default:  part[B]     = 1'b1;
                endcase
            end
            if (cur_i[B + 1]) begin
                case (cls_i)
                    C_QUOTE, C_BSLASH, C_SLASH, C_LT_B, C_LT_F,
                    C_LT_N, C_LT_R, C_LT_T: part[B]     = 1'b1;
                    C_LT_U:                 part[B + 2] = 1'b1;
                    default:                ;
                endcase
            end
            for (int k = 0; k < 3; k++)
                if (cur_i[B + 2 + k]) part[B + 3 + k] = 1'b1;
            if (cur_i[B + 5]) part[B] = 1'b1;
        end
    end

    assign nxt_o = base_nxt | g_str[0].part | g_str[1].part;

endmodule

// File: rtl/json_nfa_validator.sv
// Top of the JSON checker. Consumes one byte per in_valid strobe, advances
// the multi-hot state register and the nesting stack, and keeps a sticky
// error flag. After an error, state and stack are frozen until reset.
module json_nfa_validator
    import json_nfa_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       accept_o,
    output logic       error_o
);

    localparam int PW = $clog2(DEPTH + 1);

    char_cls_e        cls;
    logic [NFA_W-1:0] state_q;
    logic [NFA_W-1:0] next_state;
    logic             push_req, pop_req, stray;
    logic [TAG_W-1:0] push_tag, pop_tag, top_tag;
    logic [PW-1:0]    depth;
    logic             full, empty;
    logic             err_q, step, fault;

    json_char_class enc_i (
        .byte_i (in_byte),
        .cls_o  (cls)
    );

    json_nfa_next nxt_i (
        .cur_i       (state_q),
        .cls_i       (cls),
        .top_tag_i   (top_tag),
        .stk_empty_i (empty),
        .nxt_o       (next_state),
        .push_o      (push_req),
        .push_tag_o  (push_tag),
        .pop_o       (pop_req),
        .pop_tag_o   (pop_tag),
        .stray_o     (stray)
    );

    json_nest_stack #(.DEPTH(DEPTH), .W(TAG_W), .PW(PW)) stk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (step && push_req),
        .pop   (step && pop_req),
        .din   (push_tag),
        .top   (top_tag),
        .depth (depth),
        .full  (full),
        .empty (empty)
    );

    assign step  = in_valid && !err_q;
    assign fault = (next_state == '0) || stray
                || (push_req && full)
                || (pop_req && empty)
                || (pop_req && !empty && top_tag != pop_tag);

    // Advance the automaton on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= '0;
            state_q[S_VAL] <= 1'b1;
        end else if (step) begin
            state_q <= next_state;
        end
    end

    // Sticky fault latch
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (step && fault)
            err_q <= 1'b1;
    end

    assign accept_o = state_q[S_ACC] && empty && !err_q;
    assign error_o  = err_q;

endmodule

// File: rtl/json_nfa_checker.sv
// Temporal checks on the JSON checker, attached to the top through bind.
module json_nfa_checker
    import json_nfa_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             error_o,
    input logic             push_req,
    input logic             pop_req,
    input logic [PW-1:0]    depth,
    input logic [NFA_W-1:0] state_q,
    input logic [NFA_W-1:0] next_state
);

    a_r9_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> error_o);

    a_r9_frozen_after_error: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> ($stable(state_q) && $stable(depth)));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_q) && $stable(depth)));

    a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= PW'(DEPTH));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !error_o && push_req && depth == PW'(DEPTH)) |=> error_o);

    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !error_o && pop_req && depth == '0) |=> error_o);

    a_r2_dead_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !error_o && next_state == '0) |=> error_o);

endmodule

bind json_nfa_validator json_nfa_checker #(.DEPTH(DEPTH), .PW(PW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .error_o    (error_o),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .depth      (depth),
    .state_q    (state_q),
    .next_state (next_state)
);

// File: tb/json_nfa_validator_tb_top.sv
// Self-checking bench: a table of whole documents with expected flags,
// then directed tests for reset, nesting limits, stickiness and idling.
module json_nfa_validator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    // Documents are right-aligned; leading zero bytes are skipped
    localparam logic [8*24-1:0] V_TXT [NV] = '{
        "0",                       // R2
        "12",                      // R2 multi-hot
        "12,",                     // R2 comma at depth zero
        "-0.5e+3",                 // R4
        "1E5",                     // R4 upper exponent
        "1e5",                     // R4 lower exponent
        "true",                    // R4
        "truE",                    // R4 case-strict literal
        "nul",                     // R10 partial literal
        "[1,2]",                   // R3
        "{\"a\":[true,null]}",     // R3
        " [ 1 , 2 ] ",             // R8
        "1 2",                     // R8
        "\"a\\u zZ!b\"",           // R5 unchecked \u bytes
        "\"\\x\"",                 // R5 bad escape
        "[1}",                     // R7 mismatch
        "]",                       // R7 closer at depth zero
        "[1",                      // R10 unclosed
        "01",                      // R2 digit after leading zero
        "{\"k\" : false }",        // R8
        "\"\\n\\\"\"",             // R5
        "-",                       // R10 incomplete number
        "1.e"                      // R4 exponent without fraction digit
    };
    // {expected accept, expected error}
    localparam logic [1:0] V_EXP [NV] = '{
        2'b10, 2'b10, 2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b01,
        2'b00, 2'b10, 2'b10, 2'b10, 2'b01, 2'b10, 2'b01, 2'b01,
        2'b01, 2'b00, 2'b01, 2'b10, 2'b10, 2'b00, 2'b01
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       accept_o, error_o;
    int         n_checks = 0;
    int         n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    json_nfa_validator dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .accept_o (accept_o),
        .error_o  (error_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1", "accept after reset", accept_o, 1'b0);
        chk("R1", "error after reset", error_o, 1'b0);
        send(8'h35);
        chk("R1", "digit from reset state", accept_o, 1'b1);

        // Table of documents
        for (int i = 0; i < NV; i++) begin
            do_reset();
            for (int k = 23; k >= 0; k--) begin
                if (V_TXT[i][k*8 +: 8] != 8'h00) send(V_TXT[i][k*8 +: 8]);
            end
            chk("table", $sformatf("vector %0d accept", i), accept_o, V_EXP[i][1]);
            chk("table", $sformatf("vector %0d error", i), error_o, V_EXP[i][0]);
        end

        // R2: multi-hot number progress
        do_reset();
        send(8'h39);
        chk("R2", "after 9", accept_o, 1'b1);
        send(8'h38);
        chk("R2", "after 98", accept_o, 1'b1);
        send(8'h2E);
        chk("R2", "after 98.", accept_o, 1'b0);
        chk("R2", "error after 98.", error_o, 1'b0);
        send(8'h35);
        chk("R2", "after 98.5", accept_o, 1'b1);

        // R6: sixteen levels accepted
        do_reset();
        for (int k = 0; k < 16; k++) send(8'h5B);
        chk("R6", "error at depth 16", error_o, 1'b0);
        chk("R6", "accept at depth 16", accept_o, 1'b0);
        for (int k = 0; k < 16; k++) send(8'h5D);
        chk("R6", "accept after 16 closers", accept_o, 1'b1);
        chk("R6", "error after 16 closers", error_o, 1'b0);

        // R6: seventeenth opener overflows
        do_reset();
        for (int k = 0; k < 17; k++) send(8'h5B);
        chk("R6", "error at 17th opener", error_o, 1'b1);

        // R9: sticky error, cleared only by reset
        do_reset();
        send(8'h78);
        chk("R9", "error on x", error_o, 1'b1);
        send(8'h31);
        chk("R9", "error stays", error_o, 1'b1);
        chk("R9", "no accept after error", accept_o, 1'b0);
        do_reset();
        chk("R9", "reset clears error", error_o, 1'b0);

        // R11: idle cycles with a noisy byte change nothing
        do_reset();
        send(8'h37);
        in_byte = 8'h2C;
        repeat (5) @(negedge clk);
        chk("R11", "accept held while idle", accept_o, 1'b1);
        chk("R11", "no error while idle", error_o, 1'b0);
        send(8'h31);
        chk("R11", "number continues after idle", accept_o, 1'b1);

        // R12: control byte inside a string
        do_reset();
        send(8'h22);
        send(8'h61);
        chk("R12", "open string no error", error_o, 1'b0);
        send(8'h01);
        chk("R12", "control byte in string", error_o, 1'b1);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule